// File: doc/BRIEF.md
# Flash Erase Status Toggle Generator

This block sits on the read path of a NOR-style flash and produces the status byte that a host polls while an embedded program or erase runs. Two status bits toggle between successive reads. Bit 6 shows whether the device is busy with a program or erase. Bit 2 shows whether the sector being read is one of those chosen for erase. A host that reads twice and compares the two values can therefore learn both the operating mode and the erase membership of a sector.

The command decoder outside this block loads an operating mode with a one-cycle strobe. That strobe marks the rising edge of the final write-enable pulse of a command sequence. The decoder also supplies the per-sector erase mask. A completion input takes the block out of a running operation. A timeout input raises bit 5 while an operation is in progress. Reads of sectors outside the erase set during a suspend, and all reads while idle, return the array data unchanged.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset, `rd_data_o` is 0x00, the mode is idle and both toggle bits are 0, so the first status read in a busy mode returns 0 in bit 6 and in bit 2.
- R2: The mode is loaded from `mode_i` when `mode_ld_i` is high (0 idle, 1 programming, 2 erasing, 3 erase suspended, 4 programming in suspend, other codes idle). When `op_done_i` is high and no load is present, programming and erasing return to idle and programming in suspend returns to erase suspended. A load takes priority over `op_done_i`.
- R3: While idle, a read returns `array_data_i` and changes neither toggle bit.
- R4: While programming, every read at any address returns the status byte, inverts bit 6 and leaves bit 2 unchanged.
- R5: While erasing, a read in a sector whose mask bit is set inverts both bit 6 and bit 2. The sector is the top log2(NSECT) bits of `rd_addr_i`, and it selects bit `sector` of `sector_sel_i`.
- R6: While erasing, a read in a sector whose mask bit is clear inverts bit 6 and leaves bit 2 unchanged.
- R7: While erase is suspended, a read in a selected sector returns the status byte, leaves bit 6 unchanged and inverts bit 2.
- R8: While erase is suspended, a read in an unselected sector returns `array_data_i` and changes neither toggle bit.
- R9: While programming in suspend, every read inverts bit 6 and bit 2 holds its value.
- R10: The status byte carries bit 6 = toggle A, bit 2 = toggle B, and bit 5 = `timeout_i` in programming, erasing and programming-in-suspend. Bit 5 is 0 while suspended, and all other bits are 0.
- R11: `rd_data_o` updates on the clock edge that samples `rd_stb_i` high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ld_i | input | 1 | Load strobe for a new mode (final write-enable edge) |
| mode_i | input | 3 | Mode code to load |
| op_done_i | input | 1 | Embedded operation has completed |
| timeout_i | input | 1 | Operation exceeded its time limit |
| sector_sel_i | input | NSECT | Erase selection, one bit per sector |
| rd_stb_i | input | 1 | One-cycle read strobe |
| rd_addr_i | input | AW | Read address |
| array_data_i | input | 8 | Array contents at the read address |
| rd_data_o | output | 8 | Returned read byte |

## Verification
Each read result appears in `rd_data_o` one clock edge after the strobe is sampled. A mode load or completion pulse takes effect for any read strobed in a later cycle. The bench changes inputs on falling edges and holds the strobe through exactly one rising edge. It compares the output at the next falling edge, so every result is checked in the cycle it first becomes valid. Hold checks then vary the array data for several idle cycles and confirm that the output does not move.

// File: rtl/ftg_pkg.sv
`timescale 1ns/1ps
// Shared types for the erase status toggle generator.
package ftg_pkg;
    typedef enum logic [2:0] {
        FTG_IDLE      = 3'd0,
        FTG_PROG      = 3'd1,
        FTG_ERASE     = 3'd2,
        FTG_SUSP      = 3'd3,
        FTG_SUSP_PROG = 3'd4
    } ftg_mode_e;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned BIT_TGLA = 6;   // busy toggle
    localparam int unsigned BIT_TMO  = 5;   // timeout flag
    localparam int unsigned BIT_TGLB = 2;   // erase-membership toggle
    localparam int unsigned N_TGL    = 2;   // index 0: toggle A, 1: toggle B
endpackage

// File: rtl/ftg_mode_ctrl.sv
`timescale 1ns/1ps
// Holds the active operating mode.
// Assumes: mode_ld_i is a single-cycle strobe from the command decoder;
// unknown codes load idle; a load outranks completion.
module ftg_mode_ctrl
    import ftg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_ld_i,
    input  logic [2:0] mode_i,
    input  logic       op_done_i,
    output ftg_mode_e  mode_o
);
    ftg_mode_e decoded;

    // Map the raw code onto a legal mode.
    always_comb begin
        case (mode_i)
            3'd1:    decoded = FTG_PROG;
            3'd2:    decoded = FTG_ERASE;
            3'd3:    decoded = FTG_SUSP;
            3'd4:    decoded = FTG_SUSP_PROG;
            default: decoded = FTG_IDLE;
        endcase
    end

    // Mode register: load, or step back when the operation completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= FTG_IDLE;
        end else if (mode_ld_i) begin
            mode_o <= decoded;
        end else if (op_done_i) begin
            case (mode_o)
                FTG_PROG, FTG_ERASE: mode_o <= FTG_IDLE;
                FTG_SUSP_PROG:       mode_o <= FTG_SUSP;
                default:             mode_o <= mode_o;
            endcase
        end
    end
endmodule

// File: rtl/ftg_sector_sel.sv
`timescale 1ns/1ps
// Decides whether a read address falls in a sector chosen for erase.
// Assumes: NSECT is a power of two, at least 2; sector = top address bits.
module ftg_sector_sel #(
    parameter int unsigned NSECT = 8,
    parameter int unsigned AW    = 12
) (
    input  logic [AW-1:0]    addr_i,
    input  logic [NSECT-1:0] mask_i,
    output logic             hit_o
);
    localparam int unsigned SW = $clog2(NSECT);

    logic [SW-1:0] idx;

    // Extract the sector index and look up its mask bit.
    always_comb begin
        idx   = addr_i[AW-1 -: SW];
        hit_o = mask_i[idx];
    end
endmodule

// File: rtl/ftg_toggle_cell.sv
`timescale 1ns/1ps
// One status toggle: inverts on every cycle flip_i is high.
// Assumes: flip_i is already qualified by the read strobe.
module ftg_toggle_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_i,
    output logic q_o
);
    // Toggle register.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (flip_i) q_o <= ~q_o;
    end
endmodule

// File: rtl/flash_toggle_status.sv
`timescale 1ns/1ps
// Erase/program status toggle generator for a NOR-style flash read path.
// On each read strobe it registers either array data or a status byte
// whose two toggle bits follow the active mode and sector selection.
// Assumes: one-cycle rd_stb_i per read; array_data_i valid with the strobe.
module flash_toggle_status
    import ftg_pkg::*;
#(
    parameter int unsigned NSECT = 8,
    parameter int unsigned AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld_i,
    input  logic [2:0]        mode_i,
    input  logic              op_done_i,
    input  logic              timeout_i,
    input  logic [NSECT-1:0]  sector_sel_i,
    input  logic              rd_stb_i,
    input  logic [AW-1:0]     rd_addr_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    ftg_mode_e          act_mode;
    logic               hit;
    logic               use_array;
    logic               busy;
    logic [N_TGL-1:0]   flip;
    logic [N_TGL-1:0]   tgl_q;
    logic [DATA_W-1:0]  status;

    ftg_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_ld_i (mode_ld_i),
        .mode_i    (mode_i),
        .op_done_i (op_done_i),
        .mode_o    (act_mode)
    );

    ftg_sector_sel #(.NSECT(NSECT), .AW(AW)) u_sel (
        .addr_i (rd_addr_i),
        .mask_i (sector_sel_i),
        .hit_o  (hit)
    );

    for (genvar g = 0; g < N_TGL; g++) begin : g_tgl
        ftg_toggle_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .flip_i (flip[g]),
            .q_o    (tgl_q[g])
        );
    end

    // Decide which toggles invert on this read and what the read returns.
    always_comb begin
        flip      = '0;
        use_array = 1'b1;
        busy      = 1'b0;
        case (act_mode)
            FTG_PROG, FTG_SUSP_PROG: begin
                flip[0]   = rd_stb_i;
                use_array = 1'b0;
                busy      = 1'b1;
            end
            FTG_ERASE: begin
                flip[0]   = rd_stb_i;
                flip[1]   = rd_stb_i & hit;
                use_array = 1'b0;
                busy      = 1'b1;
            end
            FTG_SUSP: begin
                flip[1]   = rd_stb_i & hit;
                use_array = ~hit;
            end
            default: ;
        endcase
    end

    // Assemble the status byte from the toggles and the timeout flag.
    always_comb begin
        status           = '0;
        status[BIT_TGLA] = tgl_q[0];
        status[BIT_TGLB] = tgl_q[1];
        status[BIT_TMO]  = timeout_i & busy;
    end

    // Output register: captures the read result on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_data_o <= '0;
        else if (rd_stb_i) rd_data_o <= use_array ? array_data_i : status;
    end
endmodule

// File: rtl/ftg_checker.sv
`timescale 1ns/1ps
// Temporal checks on the toggle generator, bound to the top module.
module ftg_checker
    import ftg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld_i,
    input  logic              op_done_i,
    input  logic              timeout_i,
    input  logic              rd_stb_i,
    input  logic [DATA_W-1:0] array_data_i,
    input  logic [DATA_W-1:0] rd_data_o,
    input  logic [2:0]        act_mode
);
    logic       prev_rd;
    logic [2:0] prev_mode;

    // Remember whether the previous cycle was a read, and in which mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rd   <= 1'b0;
            prev_mode <= 3'd0;
        end else begin
            prev_rd   <= rd_stb_i;
            prev_mode <= act_mode;
        end
    end

    assert_hold_between_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> $stable(rd_data_o));

    assert_idle_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && act_mode == FTG_IDLE) |=> rd_data_o == $past(array_data_i));

    assert_prog_bit6_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && prev_rd && act_mode == FTG_PROG && prev_mode == FTG_PROG)
        |=> rd_data_o[BIT_TGLA] != $past(rd_data_o[BIT_TGLA]));

    assert_prog_bit2_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && prev_rd && act_mode == FTG_PROG && prev_mode == FTG_PROG)
        |=> rd_data_o[BIT_TGLB] == $past(rd_data_o[BIT_TGLB]));

    assert_no_tmo_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !timeout_i &&
         (act_mode == FTG_PROG || act_mode == FTG_ERASE || act_mode == FTG_SUSP_PROG))
        |=> !rd_data_o[BIT_TMO]);

    assert_done_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !mode_ld_i && (act_mode == FTG_PROG || act_mode == FTG_ERASE))
        |=> act_mode == FTG_IDLE);
endmodule

bind flash_toggle_status ftg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_ld_i    (mode_ld_i),
    .op_done_i    (op_done_i),
    .timeout_i    (timeout_i),
    .rd_stb_i     (rd_stb_i),
    .array_data_i (array_data_i),
    .rd_data_o    (rd_data_o),
    .act_mode     (act_mode)
);

// File: tb/tb_flash_toggle_status.sv
`timescale 1ns/1ps
module tb_flash_toggle_status;
    localparam int NSECT = 8;
    localparam int AW    = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_ld_i = 1'b0;
    logic [2:0]       mode_i = '0;
    logic             op_done_i = 1'b0;
    logic             timeout_i = 1'b0;
    logic [NSECT-1:0] sector_sel_i = 8'b1010_0110;
    logic             rd_stb_i = 1'b0;
    logic [AW-1:0]    rd_addr_i = '0;
    logic [7:0]       array_data_i = '0;
    logic [7:0]       rd_data_o;

    int nchk = 0;
    int nbad = 0;
    int m_mode = 0;
    bit m6 = 1'b0, m2 = 1'b0;

    always #2.5 clk = ~clk;

    flash_toggle_status #(.NSECT(NSECT), .AW(AW)) dut (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] arr_of(int a);
        return 8'((a * 37) ^ 8'h5A ^ (a >> 4));
    endfunction

    function automatic logic [7:0] stat_of(bit t6, bit t2, bit tmo);
        logic [7:0] b = '0;
        b[6] = t6; b[5] = tmo; b[2] = t2;
        return b;
    endfunction

    function automatic string req_of(int m, bit sel);
        case (m)
            1: return "R4";
            2: return sel ? "R5" : "R6";
            3: return sel ? "R7" : "R8";
            4: return "R9";
            default: return "R3";
        endcase
    endfunction

    // One read: strobe through a rising edge, compare at the next falling edge.
    task automatic do_read(int s, int off, string extra);
        logic [7:0] exp;
        bit sel = sector_sel_i[s];
        bit busy = (m_mode == 1 || m_mode == 2 || m_mode == 4);
        int a = (s << 9) | (off & 9'h1FF);
        rd_addr_i    = AW'(a);
        array_data_i = arr_of(a);
        rd_stb_i     = 1'b1;
        case (m_mode)
            1, 4: begin exp = stat_of(m6, m2, timeout_i & busy); m6 = ~m6; end
            2: begin
                exp = stat_of(m6, m2, timeout_i & busy);
                m6 = ~m6;
                if (sel) m2 = ~m2;
            end
            3: begin
                if (sel) begin exp = stat_of(m6, m2, 1'b0); m2 = ~m2; end
                else exp = arr_of(a);
            end
            default: exp = arr_of(a);
        endcase
        @(posedge clk);
        @(negedge clk);
        rd_stb_i = 1'b0;
        check({req_of(m_mode, sel), extra}, rd_data_o, exp);
    endtask

    task automatic load_mode(int m);
        mode_i = 3'(m); mode_ld_i = 1'b1;
        @(negedge clk);
        mode_ld_i = 1'b0;
        m_mode = (m <= 4) ? m : 0;
    endtask

    task automatic pulse_done();
        op_done_i = 1'b1;
        @(negedge clk);
        op_done_i = 1'b0;
        if (m_mode == 1 || m_mode == 2) m_mode = 0;
        else if (m_mode == 4) m_mode = 3;
    endtask

    initial begin
        #1000000;
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset output", rd_data_o, 8'h00);
        do_read(1, 3, " first idle read");

        // Sweep every busy mode, both timeout levels, every sector, twice.
        for (int md = 1; md <= 5; md++) begin
            load_mode(md % 5);
            for (int t = 0; t < 2; t++) begin
                timeout_i = t[0];
                for (int s = 0; s < NSECT; s++) begin
                    do_read(s, s * 11 + t, " R10 sweep");
                    do_read(s, s * 13 + 5, " R10 sweep");
                end
            end
        end
        timeout_i = 1'b0;

        // R11: output holds while array data moves and no strobe arrives.
        load_mode(1);
        do_read(2, 7, " R11 setup");
        begin
            logic [7:0] held = rd_data_o;
            for (int k = 0; k < 4; k++) begin
                array_data_i = 8'(k * 91 + 3);
                @(negedge clk);
                check("R11 hold", rd_data_o, held);
            end
        end

        // R2: completion returns programming/erasing to idle.
        pulse_done();
        do_read(5, 9, " R2 after prog done");
        load_mode(2);
        do_read(1, 2, " R2 erase load");
        pulse_done();
        do_read(1, 2, " R2 after erase done");
        // R2: programming in suspend returns to suspended.
        load_mode(4);
        do_read(0, 1, " R2");
        pulse_done();
        do_read(2, 4, " R2 back to suspend");
        do_read(2, 4, " R2 back to suspend");
        do_read(0, 4, " R2 back to suspend");
        // R2: load outranks completion in the same cycle.
        mode_i = 3'd2; mode_ld_i = 1'b1; op_done_i = 1'b1;
        @(negedge clk);
        mode_ld_i = 1'b0; op_done_i = 1'b0; m_mode = 2;
        do_read(7, 6, " R2 load priority");
        // R2: unknown code loads idle.
        load_mode(6);
        do_read(7, 6, " R2 unknown code");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule